// File: doc/BRIEF.md
# 68000-Bus to Parallel ATA Glue

This block joins a 16-bit 68000-family processor bus to a parallel ATA (IDE) drive. It decodes a small memory-mapped window into the drive's two register blocks. The command block holds the data, error, sector setup, status and command registers. The control block holds the alternate status / device control register, which software uses to mask drive interrupts. The block also turns the processor's single read/write line into the separate read and write strobes that the drive needs.

It steers the external bidirectional data buffers from the decoded cycle type, and it enables them only inside a decoded drive access. The 16-bit data lanes are byte-crossed, so that the little-endian drive data reaches the big-endian processor in the right order. The bus acknowledge follows a configurable number of wait states, so that slow drives still work at higher processor clocks. The drive's interrupt line is synchronised and presented as a fixed priority level. The matching interrupt acknowledge cycle is answered with an autovector request.

Address strobe, address and read/write are sampled on the block's clock. An access starts on the first edge that sees the strobe low with a decoded hit. All drive-side selects and the acknowledge release at once when the strobe rises.

Top module: `ide_glue`

## Requirements
- R1: While an access is live, a data-space access (space code not 7) whose byte address has bits [23:5] equal to IDE_BASE[23:5] and bit 4 = 0 asserts only ide_cmd_cs_n low. ide_reg then carries address bits [3:1].
- R2: The same window with address bit 4 = 1 asserts only ide_ctl_cs_n low, and ide_reg carries address bits [3:1].
- R3: During a decoded drive access, exactly one strobe is low: ide_rd_n when cpu_rw = 1 (read), or ide_wr_n when cpu_rw = 0 (write). Neither strobe is ever low together with the other.
- R4: buf_to_cpu is 1 during drive reads and 0 during drive writes. buf_en_n is low only while a drive chip select is asserted.
- R5: cpu_ack_n goes low after exactly WAIT_STATES+1 rising clock edges, counted from the first edge that samples cpu_as_n low with a window hit (default WAIT_STATES = 2).
- R6: When cpu_as_n is high, the chip selects, strobes, buffer enable, cpu_ack_n and cpu_avec_n are all inactive in that same cycle, with no clock edge needed.
- R7: Data lanes are byte-crossed in both directions: cpu_rdata = {ide_rdata[7:0], ide_rdata[15:8]} and ide_wdata = {cpu_wdata[7:0], cpu_wdata[15:8]}.
- R8: ide_irq passes through two flops. cpu_irq_lvl_n becomes ~IRQ_LEVEL (3'b100 for level 3) two edges after ide_irq rises. It holds while ide_irq stays high, and returns to 3'b111 two edges after ide_irq falls.
- R9: An access with space code 7 and address bits [3:1] equal to IRQ_LEVEL drives cpu_avec_n low from the first edge, with no drive strobe and no cpu_ack_n. A space-code-7 access at another level gets no response.
- R10: During reset, every active-low output is high, buf_to_cpu is 0 and cpu_irq_lvl_n is 3'b111.
- R11: An access outside the window, or a space-code-7 access inside it, produces no chip select, strobe, buffer enable or cpu_ack_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_as_n | input | 1 | Processor address strobe, active low |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_space | input | 3 | Processor address space code; 7 = CPU space |
| cpu_addr | input | 23 | Processor word address, byte address bits [23:1] |
| cpu_wdata | input | 16 | Write data from the processor |
| cpu_rdata | output | 16 | Byte-crossed read data to the processor |
| cpu_ack_n | output | 1 | Data transfer acknowledge, active low |
| cpu_avec_n | output | 1 | Autovector request for the interrupt acknowledge |
| cpu_irq_lvl_n | output | 3 | Encoded interrupt priority, active low |
| ide_cmd_cs_n | output | 1 | Command-block chip select |
| ide_ctl_cs_n | output | 1 | Control-block chip select |
| ide_rd_n | output | 1 | Drive read strobe |
| ide_wr_n | output | 1 | Drive write strobe |
| ide_reg | output | 3 | Drive register address |
| ide_wdata | output | 16 | Byte-crossed write data to the drive |
| ide_rdata | input | 16 | Read data from the drive |
| ide_irq | input | 1 | Drive interrupt request, active high |
| buf_to_cpu | output | 1 | Buffer direction, 1 = drive toward processor |
| buf_en_n | output | 1 | Buffer output enable, active low |

## Verification
The interrupt path and the access sequencer run side by side, so a drive interrupt can change level in the same cycle that a write strobe is live. The bench drops ide_irq on the same clock on which it lowers the address strobe for a command-block write. It then checks at the cycle boundary that the write strobe, chip select and buffer direction stay correct while the priority output follows its own two-flop delay. In another case a level-3 interrupt is held pending while an interrupt acknowledge cycle runs. That acknowledge must raise the autovector request and nothing on the drive side.

// File: rtl/ide_glue_pkg.sv
package ide_glue_pkg;

  localparam int DATA_W  = 16;
  localparam int LANES   = DATA_W / 8;
  localparam int REG_AW  = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_IACK = 2'd3
  } sel_e;

  // Reverse the byte lanes of a data word (endian crossing).
  function automatic logic [DATA_W-1:0] cross_lanes(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      r[i*8 +: 8] = v[(LANES-1-i)*8 +: 8];
    end
    return r;
  endfunction

  // True when the wait counter has reached its limit.
  function automatic logic wait_reached(input logic [7:0] cnt, input logic [7:0] lim);
    return cnt == lim;
  endfunction

  // Active-low encoding of an interrupt priority level.
  function automatic logic [2:0] level_code_n(input logic pending, input logic [2:0] lvl);
    return pending ? ~lvl : 3'b111;
  endfunction

endpackage

// File: rtl/ide_decode.sv
module ide_decode
  import ide_glue_pkg::*;
#(
  parameter int              ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] IDE_BASE = 24'hF0_0000,
  parameter logic [2:0]      IRQ_LEVEL = 3'd3
) (
  input  logic [ADDR_W-1:1] addr,
  input  logic [2:0]        space,
  output sel_e              sel,
  output logic [REG_AW-1:0] reg_idx
);
  localparam int TAG_LSB = REG_AW + 2;

  logic cpu_space_cyc;
  logic window_hit;
  logic level_match;

  assign cpu_space_cyc = (space == 3'b111);
  assign window_hit    = (addr[ADDR_W-1:TAG_LSB] == IDE_BASE[ADDR_W-1:TAG_LSB]);
  assign level_match   = (addr[REG_AW:1] == IRQ_LEVEL);
  assign reg_idx       = addr[REG_AW:1];

  always_comb begin
    sel = SEL_NONE;
    if (cpu_space_cyc) begin
      if (level_match) sel = SEL_IACK;
    end else if (window_hit) begin
      sel = addr[TAG_LSB-1] ? SEL_CTL : SEL_CMD;
    end
  end

endmodule

// File: rtl/ide_cycle_ctl.sv
module ide_cycle_ctl
  import ide_glue_pkg::*;
#(
  parameter int WAIT_STATES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_n,
  input  logic              rw,
  input  sel_e              sel,
  input  logic [REG_AW-1:0] reg_idx,
  output logic              cmd_cs_n,
  output logic              ctl_cs_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [REG_AW-1:0] da,
  output logic              to_cpu,
  output logic              en_n,
  output logic              ack_n,
  output logic              avec_n
);
  localparam int CNT_W = $clog2(WAIT_STATES + 2);
  localparam logic [CNT_W-1:0] WAIT_LIM = CNT_W'(WAIT_STATES);

  logic              active_q;
  sel_e              sel_q;
  logic              rw_q;
  logic [REG_AW-1:0] da_q;
  logic [CNT_W-1:0]  cnt_q;

  // Named internal events
  logic live;
  logic ide_cyc;
  logic wait_done;
  logic start_cyc;

  assign start_cyc = !as_n && !active_q && (sel != SEL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sel_q    <= SEL_NONE;
      rw_q     <= 1'b1;
      da_q     <= '0;
      cnt_q    <= '0;
    end else if (as_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_cyc) begin
      active_q <= 1'b1;
      sel_q    <= sel;
      rw_q     <= rw;
      da_q     <= reg_idx;
      cnt_q    <= '0;
    end else if (active_q && !wait_done) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign live      = active_q && !as_n;
  assign ide_cyc   = live && (sel_q == SEL_CMD || sel_q == SEL_CTL);
  assign wait_done = wait_reached(8'(cnt_q), 8'(WAIT_LIM));

  assign cmd_cs_n = !(live && sel_q == SEL_CMD);
  assign ctl_cs_n = !(live && sel_q == SEL_CTL);
  assign rd_n     = !(ide_cyc && rw_q);
  assign wr_n     = !(ide_cyc && !rw_q);
  assign da       = da_q;
  assign to_cpu   = ide_cyc && rw_q;
  assign en_n     = !ide_cyc;
  assign ack_n    = !(ide_cyc && wait_done);
  assign avec_n   = !(live && sel_q == SEL_IACK);

  // R3: the two strobes are never low together
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R4: buffers are enabled only with a drive select asserted
  p_buf_in_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_n |-> (cmd_cs_n != ctl_cs_n));

  // R4: direction does not change during an enabled access
  p_dir_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && $past(!en_n)) |-> $stable(to_cpu));

  // R5: acknowledge only after the strobe was already low an edge earlier
  p_ack_after_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> $past(!as_n));

  // R6: nothing is active once the address strobe is high
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> (cmd_cs_n && ctl_cs_n && rd_n && wr_n && en_n && ack_n && avec_n));

  // R9: the autovector answer never touches the drive
  p_iack_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !avec_n |-> (rd_n && wr_n && ack_n));

endmodule

// File: rtl/ide_irq_sync.sv
module ide_irq_sync
  import ide_glue_pkg::*;
#(
  parameter logic [2:0] IRQ_LEVEL = 3'd3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_in,
  output logic [2:0] lvl_n
);
  logic meta_q;
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      meta_q <= irq_in;
      pend_q <= meta_q;
    end
  end

  assign lvl_n = level_code_n(pend_q, IRQ_LEVEL);

  // R8: pending rises only two edges after the drive line rose
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(irq_in, 2));

  // R8: pending clears only two edges after the drive line fell
  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> !$past(irq_in, 2));

endmodule

// File: rtl/ide_glue.sv
module ide_glue
  import ide_glue_pkg::*;
#(
  parameter int                ADDR_W      = 24,
  parameter logic [ADDR_W-1:0] IDE_BASE    = 24'hF0_0000,
  parameter int                WAIT_STATES = 2,
  parameter logic [2:0]        IRQ_LEVEL   = 3'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_as_n,
  input  logic              cpu_rw,
  input  logic [2:0]        cpu_space,
  input  logic [ADDR_W-1:1] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ack_n,
  output logic              cpu_avec_n,
  output logic [2:0]        cpu_irq_lvl_n,
  output logic              ide_cmd_cs_n,
  output logic              ide_ctl_cs_n,
  output logic              ide_rd_n,
  output logic              ide_wr_n,
  output logic [REG_AW-1:0] ide_reg,
  output logic [DATA_W-1:0] ide_wdata,
  input  logic [DATA_W-1:0] ide_rdata,
  input  logic              ide_irq,
  output logic              buf_to_cpu,
  output logic              buf_en_n
);
  sel_e              dec_sel;
  logic [REG_AW-1:0] dec_reg;

  ide_decode #(
    .ADDR_W   (ADDR_W),
    .IDE_BASE (IDE_BASE),
    .IRQ_LEVEL(IRQ_LEVEL)
  ) u_decode (
    .addr   (cpu_addr),
    .space  (cpu_space),
    .sel    (dec_sel),
    .reg_idx(dec_reg)
  );

  ide_cycle_ctl #(
    .WAIT_STATES(WAIT_STATES)
  ) u_cycle (
    .clk     (clk),
    .rst_n   (rst_n),
    .as_n    (cpu_as_n),
    .rw      (cpu_rw),
    .sel     (dec_sel),
    .reg_idx (dec_reg),
    .cmd_cs_n(ide_cmd_cs_n),
    .ctl_cs_n(ide_ctl_cs_n),
    .rd_n    (ide_rd_n),
    .wr_n    (ide_wr_n),
    .da      (ide_reg),
    .to_cpu  (buf_to_cpu),
    .en_n    (buf_en_n),
    .ack_n   (cpu_ack_n),
    .avec_n  (cpu_avec_n)
  );

  ide_irq_sync #(
    .IRQ_LEVEL(IRQ_LEVEL)
  ) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .irq_in(ide_irq),
    .lvl_n (cpu_irq_lvl_n)
  );

  // R7: byte-lane crossing in both directions
  assign cpu_rdata = cross_lanes(ide_rdata);
  assign ide_wdata = cross_lanes(cpu_wdata);

  // R1/R2: at most one drive select at a time
  p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ide_cmd_cs_n, ~ide_ctl_cs_n}) <= 1);

endmodule

// File: tb/ide_glue_bench.sv
module ide_glue_bench;
  localparam int WAITS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_as_n = 1'b1;
  logic        cpu_rw = 1'b1;
  logic [2:0]  cpu_space = 3'd5;
  logic [23:0] baddr = 24'h0;
  logic [15:0] cpu_wdata = 16'h0;
  logic [15:0] cpu_rdata;
  logic        cpu_ack_n, cpu_avec_n;
  logic [2:0]  cpu_irq_lvl_n;
  logic        ide_cmd_cs_n, ide_ctl_cs_n, ide_rd_n, ide_wr_n;
  logic [2:0]  ide_reg;
  logic [15:0] ide_wdata;
  logic [15:0] ide_rdata = 16'h0;
  logic        ide_irq = 1'b0;
  logic        buf_to_cpu, buf_en_n;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  ide_glue #(.WAIT_STATES(WAITS)) u_ide_glue (
    .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_rw(cpu_rw),
    .cpu_space(cpu_space), .cpu_addr(baddr[23:1]), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ack_n(cpu_ack_n), .cpu_avec_n(cpu_avec_n),
    .cpu_irq_lvl_n(cpu_irq_lvl_n), .ide_cmd_cs_n(ide_cmd_cs_n),
    .ide_ctl_cs_n(ide_ctl_cs_n), .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n),
    .ide_reg(ide_reg), .ide_wdata(ide_wdata), .ide_rdata(ide_rdata),
    .ide_irq(ide_irq), .buf_to_cpu(buf_to_cpu), .buf_en_n(buf_en_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // kind: 0 none, 1 command block, 2 control block, 3 autovector
  typedef struct packed {
    logic [23:0] addr;
    logic        rw;
    logic [2:0]  space;
    logic [1:0]  kind;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{24'hF00000, 1'b1, 3'd5, 2'd1},
    '{24'hF0000E, 1'b0, 3'd5, 2'd1},
    '{24'hF0001C, 1'b1, 3'd5, 2'd2},
    '{24'hF0001C, 1'b0, 3'd1, 2'd2},
    '{24'hF00020, 1'b1, 3'd5, 2'd0},
    '{24'hE00000, 1'b0, 3'd5, 2'd0},
    '{24'hF00004, 1'b1, 3'd7, 2'd0},
    '{24'hFFFFF6, 1'b1, 3'd7, 2'd3},
    '{24'h000006, 1'b1, 3'd7, 2'd3}
  };

  task automatic check_idle(input string req);
    check({req, " cmd_cs"}, 32'(ide_cmd_cs_n), 32'd1);
    check({req, " ctl_cs"}, 32'(ide_ctl_cs_n), 32'd1);
    check({req, " strobes"}, 32'({ide_rd_n, ide_wr_n}), 32'd3);
    check({req, " buf_en"}, 32'(buf_en_n), 32'd1);
    check({req, " ack"}, 32'(cpu_ack_n), 32'd1);
    check({req, " avec"}, 32'(cpu_avec_n), 32'd1);
  endtask

  task automatic run_vec(input vec_t v);
    int n;
    @(negedge clk);
    baddr = v.addr; cpu_rw = v.rw; cpu_space = v.space;
    cpu_wdata = 16'h3456; ide_rdata = 16'h12AB;
    cpu_as_n = 1'b0;
    @(negedge clk);
    if (v.kind == 2'd1 || v.kind == 2'd2) begin
      check("R1 cmd select", 32'(ide_cmd_cs_n), (v.kind == 2'd1) ? 32'd0 : 32'd1);
      check("R2 ctl select", 32'(ide_ctl_cs_n), (v.kind == 2'd2) ? 32'd0 : 32'd1);
      check("R1 register index", 32'(ide_reg), 32'(v.addr[3:1]));
      check("R3 read strobe", 32'(ide_rd_n), 32'(!v.rw));
      check("R3 write strobe", 32'(ide_wr_n), 32'(v.rw));
      check("R4 direction", 32'(buf_to_cpu), 32'(v.rw));
      check("R4 enable", 32'(buf_en_n), 32'd0);
      n = 1;
      while (cpu_ack_n && n < 40) begin
        @(negedge clk);
        n++;
      end
      check("R5 wait count", 32'(n), 32'(WAITS + 1));
      if (v.rw) check("R7 read crossing", 32'(cpu_rdata), 32'h0000AB12);
      else      check("R7 write crossing", 32'(ide_wdata), 32'h00005634);
    end else if (v.kind == 2'd3) begin
      check("R9 autovector", 32'(cpu_avec_n), 32'd0);
      check("R9 no strobe", 32'({ide_rd_n, ide_wr_n}), 32'd3);
      repeat (3) @(negedge clk);
      check("R9 no ack", 32'(cpu_ack_n), 32'd1);
    end else begin
      repeat (4) @(negedge clk);
      check_idle("R11 no response");
    end
    cpu_as_n = 1'b1;
    #1;
    check_idle("R6 release");
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10: reset state
    check_idle("R10 reset");
    check("R10 direction", 32'(buf_to_cpu), 32'd0);
    check("R10 irq level", 32'(cpu_irq_lvl_n), 32'd7);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 9; i++) run_vec(VECS[i]);

    // R8: interrupt synchroniser latency
    @(negedge clk);
    ide_irq = 1'b1;
    @(negedge clk);
    check("R8 one edge", 32'(cpu_irq_lvl_n), 32'd7);
    @(negedge clk);
    check("R8 two edges", 32'(cpu_irq_lvl_n), 32'd4);
    repeat (5) @(negedge clk);
    check("R8 held", 32'(cpu_irq_lvl_n), 32'd4);

    // R9 while pending: acknowledge cycle at the level
    run_vec('{24'hFFFFF6, 1'b1, 3'd7, 2'd3});
    check("R8 still pending", 32'(cpu_irq_lvl_n), 32'd4);

    // Concurrency: line drops on the edge a write begins
    @(negedge clk);
    baddr = 24'hF0000A; cpu_rw = 1'b0; cpu_space = 3'd5;
    cpu_wdata = 16'hBEEF;
    cpu_as_n = 1'b0; ide_irq = 1'b0;
    @(negedge clk);
    check("R3 write during irq", 32'({ide_rd_n, ide_wr_n}), 32'd2);
    check("R8 level kept", 32'(cpu_irq_lvl_n), 32'd4);
    @(negedge clk);
    check("R8 level cleared", 32'(cpu_irq_lvl_n), 32'd7);
    check("R1 select held", 32'(ide_cmd_cs_n), 32'd0);
    check("R4 toward drive", 32'(buf_to_cpu), 32'd0);
    check("R7 write lanes", 32'(ide_wdata), 32'h0000EFBE);
    check("R5 not yet", 32'(cpu_ack_n), 32'd1);
    @(negedge clk);
    check("R5 ack", 32'(cpu_ack_n), 32'd0);
    cpu_as_n = 1'b1;
    #1;
    check_idle("R6 early release");
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule